// File: doc/BRIEF.md
# I2C Slave Address Receiver

This block is the target-side front end of an I2C bus link that uses 7-bit addressing. It samples SCL and SDA with the system clock and picks out START and STOP from them. Once enabled, it waits for a START. It then shifts in the address byte on rising SCL edges and compares the upper seven bits with a programmed own address.

On a match it pulls SDA low during the ninth clock, and only if neither the buffer-full flag nor the overflow flag is already set. It then either receives data bytes into a single buffer or sends bytes from that buffer. For a read, it holds SCL low after the acknowledge clock. The line stays low until software has loaded a byte and pulses a release input.

Both bus lines are open-drain: each has an input and an active-high output enable that pulls the wire low. The block reports the following state:
- the buffer contents
- a buffer-full flag
- an overflow flag
- the direction bit taken from the address
- a data/address indicator
- a flag that is raised once per byte

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, scl_oe and sda_oe are 0, and buf_full, ovf, irq, rw_stat and da_stat are 0.
- R2: While enable is 0 the block never drives either line. When enabled it ignores bus bits until it sees a START: SDA falling while SCL is high. Bytes clocked without a START get no acknowledge.
- R3: Address bits are sampled on rising SCL edges, MSB first. The first seven bits are compared with own_addr. On a match the block drives SDA low for the whole ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next START.
- R4: An address byte gets no acknowledge when buf_full or ovf is 1 at the end of its eighth bit, even if the address matches.
- R5: On an acknowledged address, the whole address byte is loaded into rx_buf, buf_full and irq become 1, da_stat becomes 0, and rw_stat takes the eighth bit (1 = read).
- R6: Each data byte received after a write address is acknowledged, placed in rx_buf (MSB received first), and sets buf_full, irq and da_stat to 1.
- R7: A data byte that completes while buf_full or ovf is 1 is not acknowledged. It sets ovf and leaves rx_buf unchanged.
- R8: A buf_rd pulse clears buf_full, an irq_clr pulse clears irq and an ovf_clr pulse clears ovf. Otherwise these flags hold their values.
- R9: After the acknowledge clock of a read address, and after every byte the master acknowledges, scl_oe stays 1 until a rel_scl pulse. It drops the cycle after that pulse.
- R10: A tx_wr pulse loads tx_data into rx_buf and sets buf_full. The rel_scl pulse moves that byte to the output, clears buf_full, and sends it MSB first. After the eighth bit, irq and da_stat become 1.
- R11: A master NACK on a sent byte, or a STOP at any time, returns the block to waiting for a START with both lines released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; 0 forces idle and releases the lines |
| own_addr | input | 7 | Programmed slave address |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| tx_wr | input | 1 | Pulse: load tx_data into the buffer |
| tx_data | input | 8 | Byte to send |
| buf_rd | input | 1 | Pulse: software has read the buffer, clears buf_full |
| rel_scl | input | 1 | Pulse: release a held SCL and start sending |
| irq_clr | input | 1 | Pulse: clear irq |
| ovf_clr | input | 1 | Pulse: clear ovf |
| rx_buf | output | 8 | Buffer register |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf | output | 1 | A byte arrived while the buffer was still full |
| rw_stat | output | 1 | Direction bit of the last acknowledged address |
| da_stat | output | 1 | 0 after an address byte, 1 after a data byte |
| irq | output | 1 | Set once per transferred byte |

## Verification
A wrong bit count or a wrong state shows up within one byte. The acknowledge appears on the wrong clock or is missing, and the master reads this straight back as the ninth bit. A wrong buffer or flag update shows on rx_buf, buf_full, ovf and da_stat at the ninth falling edge. A missed hold or a missed release shows on scl_oe a few cycles after the acknowledge clock. A transmit shift error corrupts the byte the master reassembles from SDA.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADEC,
        ST_ACK,
        ST_HOLD,
        ST_TX,
        ST_TXACK,
        ST_TXWAIT,
        ST_RX,
        ST_RDEC,
        ST_SKIP
    } i2cs_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    // An acknowledge needs a match and room in the buffer.
    function automatic logic may_ack(input logic hit, input logic full, input logic over);
        return hit && !full && !over;
    endfunction

endpackage

// File: rtl/i2cs_line_mon.sv
module i2cs_line_mon
    import i2cs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.scl_rise = scl_i && !scl_q;
        ev.scl_fall = !scl_i && scl_q;
        ev.start    = scl_i && scl_q && sda_q && !sda_i;
        ev.stop     = scl_i && scl_q && !sda_q && sda_i;
    end
endmodule

// File: rtl/i2cs_shifter.sv
module i2cs_shifter #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          sh_in,
    input  logic          sh_out,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic          bit_in,
    output logic [W-1:0]  sr,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            cnt <= '0;
        end else if (load) begin
            sr  <= load_val;
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (sh_in) begin
            sr  <= {sr[W-2:0], bit_in};
            cnt <= cnt + 1'b1;
        end else if (sh_out) begin
            sr  <= {sr[W-2:0], 1'b0};
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(W)); // R3
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
    import i2cs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              buf_rd,
    input  logic              rel_scl,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    output logic [DATA_W-1:0] rx_buf,
    output logic              buf_full,
    output logic              ovf,
    output logic              rw_stat,
    output logic              da_stat,
    output logic              irq
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    line_ev_t          ev;
    i2cs_state_e       st, st_n;
    logic [DATA_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    logic sh_clr, sh_in, sh_out, sh_load;
    logic cap_addr, cap_data, ovf_set, tx_done;

    i2cs_line_mon u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cs_shifter #(.W(DATA_W), .CW(CNT_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (sh_clr),
        .sh_in    (sh_in),
        .sh_out   (sh_out),
        .load     (sh_load),
        .load_val (rx_buf),
        .bit_in   (sda_i),
        .sr       (sr),
        .cnt      (cnt)
    );

    always_comb begin
        st_n     = st;
        sh_clr   = 1'b0;
        sh_in    = 1'b0;
        sh_out   = 1'b0;
        sh_load  = 1'b0;
        cap_addr = 1'b0;
        cap_data = 1'b0;
        ovf_set  = 1'b0;
        tx_done  = 1'b0;
        if (!enable || ev.stop) begin
            st_n = ST_IDLE;
        end else if (ev.start) begin
            st_n   = ST_ADDR;
            sh_clr = 1'b1;
        end else begin
            unique case (st)
                ST_ADDR: if (ev.scl_rise) begin
                    sh_in = 1'b1;
                    if (cnt == LAST_BIT) st_n = ST_ADEC;
                end
                ST_ADEC: if (ev.scl_fall) begin
                    if (may_ack(sr[DATA_W-1:1] == own_addr, buf_full, ovf)) begin
                        cap_addr = 1'b1;
                        st_n     = ST_ACK;
                    end else begin
                        st_n = ST_SKIP;
                    end
                end
                ST_ACK: if (ev.scl_fall) begin
                    if (rw_stat) begin
                        st_n = ST_HOLD;
                    end else begin
                        st_n   = ST_RX;
                        sh_clr = 1'b1;
                    end
                end
                ST_HOLD: if (rel_scl) begin
                    sh_load = 1'b1;
                    st_n    = ST_TX;
                end
                ST_TX: if (ev.scl_fall) begin
                    if (cnt == LAST_BIT) begin
                        tx_done = 1'b1;
                        st_n    = ST_TXACK;
                    end else begin
                        sh_out = 1'b1;
                    end
                end
                ST_TXACK: if (ev.scl_rise) st_n = sda_i ? ST_IDLE : ST_TXWAIT;
                ST_TXWAIT: if (ev.scl_fall) st_n = ST_HOLD;
                ST_RX: if (ev.scl_rise) begin
                    sh_in = 1'b1;
                    if (cnt == LAST_BIT) st_n = ST_RDEC;
                end
                ST_RDEC: if (ev.scl_fall) begin
                    if (buf_full || ovf) begin
                        ovf_set = 1'b1;
                        st_n    = ST_SKIP;
                    end else begin
                        cap_data = 1'b1;
                        st_n     = ST_ACK;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            rx_buf   <= '0;
            buf_full <= 1'b0;
            ovf      <= 1'b0;
            rw_stat  <= 1'b0;
            da_stat  <= 1'b0;
            irq      <= 1'b0;
        end else begin
            st <= st_n;
            if (cap_addr) begin
                rx_buf   <= sr;
                buf_full <= 1'b1;
                da_stat  <= 1'b0;
                rw_stat  <= sr[0];
            end else if (cap_data) begin
                rx_buf   <= sr;
                buf_full <= 1'b1;
                da_stat  <= 1'b1;
            end else if (sh_load) begin
                buf_full <= 1'b0;
            end else if (tx_wr) begin
                rx_buf   <= tx_data;
                buf_full <= 1'b1;
            end else if (buf_rd) begin
                buf_full <= 1'b0;
            end
            if (tx_done) da_stat <= 1'b1;
            irq <= cap_addr || cap_data || tx_done || (irq && !irq_clr);
            ovf <= ovf_set || (ovf && !ovf_clr);
        end
    end

    assign scl_oe = (st == ST_HOLD);
    assign sda_oe = (st == ST_ACK) || ((st == ST_TX) && !sr[DATA_W-1]);

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst) !enable |=> (!sda_oe && !scl_oe)); // R2
    AST_ACK_BLOCKED: assert property (@(posedge clk) disable iff (rst) (enable && st == ST_ADEC && ev.scl_fall && !ev.start && !ev.stop && (buf_full || ovf)) |=> !sda_oe); // R4
    AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst) $rose(ovf) |-> ($past(buf_full) || $past(ovf))); // R7
    AST_OVF_KEEPS_BUF: assert property (@(posedge clk) disable iff (rst) $rose(ovf) |-> $stable(rx_buf)); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst) (irq && !irq_clr) |=> irq); // R8
    AST_SCL_HELD: assert property (@(posedge clk) disable iff (rst) (enable && st == ST_HOLD && !rel_scl && !ev.start && !ev.stop) |=> scl_oe); // R9
    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst) (enable && st == ST_TXACK && ev.scl_rise && sda_i && !ev.start && !ev.stop) |=> (!sda_oe && !scl_oe)); // R11
endmodule

// File: tb/i2c_addr_slave_tb_top.sv
module i2c_addr_slave_tb_top;
    localparam int H = 4;
    localparam logic [6:0] OWN = 7'h2A;
    // entry: {address[6:0], data[7:0], expect_ack}
    localparam logic [15:0] VEC [6] = '{
        {7'h2A, 8'hA5, 1'b1},
        {7'h2B, 8'h11, 1'b0},
        {7'h2A, 8'h3C, 1'b1},
        {7'h6A, 8'h00, 1'b0},
        {7'h2A, 8'hFF, 1'b1},
        {7'h2A, 8'h00, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic tx_wr = 1'b0, buf_rd = 1'b0, rel_scl = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic scl_oe, sda_oe, buf_full, ovf, rw_stat, da_stat, irq;
    logic [7:0] rx_buf;
    wire scl_w = scl_m & ~scl_oe;
    wire sda_w = sda_m & ~sda_oe;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    i2c_addr_slave dut_i (
        .clk(clk), .rst(rst), .enable(enable), .own_addr(OWN),
        .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .tx_wr(tx_wr), .tx_data(tx_data), .buf_rd(buf_rd), .rel_scl(rel_scl),
        .irq_clr(irq_clr), .ovf_clr(ovf_clr), .rx_buf(rx_buf), .buf_full(buf_full),
        .ovf(ovf), .rw_stat(rw_stat), .da_stat(da_stat), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_high();
        scl_m = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            if (scl_w) break;
            @(negedge clk);
        end
        wait_clk(H);
    endtask

    task automatic send_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b0; wait_clk(H);
    endtask

    task automatic send_stop();
        sda_m = 1'b0; wait_clk(H);
        scl_high();
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wait_clk(H);
        scl_high();
        scl_m = 1'b0; wait_clk(H);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_clk(H);
        scl_high();
        b = sda_w;
        scl_m = 1'b0; wait_clk(H);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic nack);
        logic b;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            d = {d[6:0], b};
        end
        put_bit(nack);
    endtask

    task automatic pulse_rd();
        buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0;
    endtask
    task automatic pulse_irq_clr();
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    endtask
    task automatic pulse_ovf_clr();
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    endtask
    task automatic pulse_tx(input logic [7:0] d);
        tx_data = d; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
    endtask
    task automatic pulse_rel();
        rel_scl = 1'b1; @(negedge clk); rel_scl = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] rb;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R1: reset state
        chk("R1 outputs", {30'd0, scl_oe, sda_oe}, 32'd0);
        chk("R1 flags", {27'd0, buf_full, ovf, irq, rw_stat, da_stat}, 32'd0);

        // R2: disabled block ignores a full address byte
        send_start();
        write_byte({OWN, 1'b0}, ack);
        chk("R2 disabled ack", ack, 0);
        send_stop();
        enable = 1'b1;
        wait_clk(H);
        // R2: no START, bits ignored
        write_byte({OWN, 1'b0}, ack);
        chk("R2 no start ack", ack, 0);
        chk("R2 no start irq", irq, 0);
        send_stop();

        // table of write transactions: R3, R5, R6, R8
        foreach (VEC[k]) begin
            logic [6:0] a7;
            logic [7:0] dv;
            logic       ex;
            {a7, dv, ex} = VEC[k];
            send_start();
            write_byte({a7, 1'b0}, ack);
            chk("R3 address ack", ack, ex);
            if (ex) begin
                chk("R5 addr in buffer", rx_buf, {a7, 1'b0});
                chk("R5 flags", {28'd0, buf_full, irq, da_stat, rw_stat}, 32'b1100);
                pulse_rd();
                pulse_irq_clr();
                chk("R8 clears", {30'd0, buf_full, irq}, 32'd0);
                write_byte(dv, ack);
                chk("R6 data ack", ack, 1);
                chk("R6 data buffer", rx_buf, dv);
                chk("R6 flags", {29'd0, buf_full, irq, da_stat}, 32'b111);
                pulse_rd();
                pulse_irq_clr();
            end else begin
                write_byte(dv, ack);
                chk("R3 skip data ack", ack, 0);
                chk("R3 skip irq", irq, 0);
            end
            send_stop();
        end

        // R4: full buffer blocks address ack
        send_start();
        write_byte({OWN, 1'b0}, ack);
        chk("R3 ack before R4", ack, 1);
        send_stop();
        send_start();
        write_byte({OWN, 1'b0}, ack);
        chk("R4 nack when full", ack, 0);
        send_stop();
        pulse_rd();
        pulse_irq_clr();

        // R7: data byte while full -> overflow, nack, buffer kept
        send_start();
        write_byte({OWN, 1'b0}, ack);
        write_byte(8'h77, ack);
        chk("R7 nack", ack, 0);
        chk("R7 ovf", ovf, 1);
        chk("R7 buffer kept", rx_buf, {OWN, 1'b0});
        send_stop();
        pulse_rd();
        pulse_irq_clr();
        // R4: overflow alone blocks address ack
        send_start();
        write_byte({OWN, 1'b0}, ack);
        chk("R4 nack when ovf", ack, 0);
        send_stop();
        pulse_ovf_clr();
        chk("R8 ovf cleared", ovf, 0);

        // R11: STOP mid-byte, then a fresh transfer works
        send_start();
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        send_stop();
        send_start();
        write_byte({OWN, 1'b0}, ack);
        chk("R11 after stop ack", ack, 1);
        send_stop();
        pulse_rd();
        pulse_irq_clr();

        // R9, R10, R11: read transfer
        send_start();
        write_byte({OWN, 1'b1}, ack);
        chk("R3 read ack", ack, 1);
        chk("R5 read rw", rw_stat, 1);
        chk("R5 read buffer", rx_buf, {OWN, 1'b1});
        wait_clk(16);
        chk("R9 scl held", scl_oe, 1);
        scl_m = 1'b1;
        wait_clk(4);
        chk("R9 line low", scl_w, 0);
        pulse_rd();
        pulse_irq_clr();
        pulse_tx(8'hC6);
        chk("R10 tx load full", buf_full, 1);
        pulse_rel();
        chk("R9 released", scl_oe, 0);
        chk("R10 full cleared", buf_full, 0);
        read_byte(rb, 1'b0);
        chk("R10 byte1", rb, 8'hC6);
        chk("R10 irq da", {30'd0, irq, da_stat}, 32'b11);
        wait_clk(4);
        chk("R9 held again", scl_oe, 1);
        pulse_irq_clr();
        pulse_tx(8'h5A);
        pulse_rel();
        read_byte(rb, 1'b1);
        chk("R10 byte2", rb, 8'h5A);
        wait_clk(4);
        chk("R11 nack release", {30'd0, scl_oe, sda_oe}, 32'd0);
        write_byte({OWN, 1'b0}, ack);
        chk("R11 idle after nack", ack, 0);
        send_stop();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule